// File: doc/BRIEF.md
# Modem Control Loopback Unit

This block sits beside the control and line-control registers of a UART and implements its self-test loopback path. When the loopback enable bit of the control register is set, the four modem control outputs that software drives are fed back as the modem status flags. Each control register write made with loopback enabled also refreshes the modem status interrupts so that they match the looped levels. With loopback off, the flags track the external modem input pins instead.

The same enable redirects traffic. Every transmit data write is copied into the receive buffer, and a rising send-break request is copied there as a break entry. Characters from the external receive input are dropped while loopback is enabled and passed through while it is off. The block does not hold the receive buffer. It issues single-cycle push requests, and the buffer stores whatever it is offered. Interrupt changes leave the block as set and clear request vectors, which the interrupt status register applies.

Top module: `mcl_loopback`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is zero.
- R2: A control write with bit 7 (loopback enable) set updates the flags one cycle later. Flag bit 0 takes control bit 11, flag bit 1 takes control bit 10, flag bit 2 takes control bit 12, and flag bit 8 takes control bit 13. The looped values hold until the next control write.
- R3: While loopback is off, the flags sample `extModem` one cycle late. `extModem[0]` drives flag bit 0, `extModem[1]` drives flag bit 1, `extModem[2]` drives flag bit 2, and `extModem[3]` drives flag bit 8.
- R4: A control write with bit 7 set causes one pulse, one cycle later. In that pulse `msIntClr` is 4'hF and `msIntSet` carries the new looped levels in the order bit0 = clear-to-send, bit1 = data-set-ready, bit2 = carrier detect, bit3 = ring. The receiver clears first and then sets. This happens even when only the enable bit changes. A control write with bit 7 clear gives no pulse.
- R5: A transmit write while loopback is active produces a push one cycle later. The push data is the byte zero-extended to 11 bits.
- R6: An external receive character is pushed one cycle later when loopback is inactive. It is discarded, with no push, when loopback is active.
- R7: A line-control write with the break bit set produces a push of 11'h400 one cycle later. This happens only when the previously stored break bit was clear and loopback is active. The break bit is stored on every line-control write, whatever the loopback state.
- R8: A control write changes `loopbackActive` one cycle later. Transmit, receive and break inputs are judged against the loopback state held before a control write in the same cycle.
- R9: Flag bits 3 to 7 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 16 | Control register write value |
| lineWrEn | input | 1 | Line-control register write strobe |
| lineBreak | input | 1 | Send-break bit of the line-control write value |
| txWrEn | input | 1 | Transmit data write strobe |
| txData | input | 8 | Transmit data byte |
| extRxValid | input | 1 | External receive character strobe |
| extRxData | input | 8 | External receive character |
| extModem | input | 4 | External modem inputs: CTS, DSR, DCD, RI (bits 0 to 3) |
| flagBits | output | 9 | Modem status flag bits (0 CTS, 1 DSR, 2 DCD, 8 RI) |
| msIntSet | output | 4 | Modem interrupt set requests |
| msIntClr | output | 4 | Modem interrupt clear requests |
| rxPushValid | output | 1 | Receive buffer push strobe |
| rxPushData | output | 11 | Receive buffer push entry, bit 10 marks a break |
| loopbackActive | output | 1 | Current loopback enable state |

## Verification
The push port can carry only one entry per cycle. The assertions therefore assume that a transmit write and a line-control write never arrive in the same cycle. The stimulus keeps them mutually exclusive in both the directed and the random phases. Any other mix of inputs is allowed, including a control write that lands in the same cycle as transmit, receive or break traffic. That case exercises the rule in R8 that the loopback state in force before the write is the one that applies.

// File: rtl/mcl_pkg.sv
package mcl_pkg;
  localparam int MODEM_N = 4;

  typedef struct packed {
    logic               loopNow;
    logic               loopNext;
    logic               refresh;
    logic [MODEM_N-1:0] levels;
    logic               pushTx;
    logic               pushBrk;
    logic               pushExt;
  } mcl_strobe_t;
endpackage

// File: rtl/mcl_ctrl.sv
module mcl_ctrl
  import mcl_pkg::*;
#(
  parameter int CTRL_W   = 16,
  parameter int LBE_BIT  = 7,
  parameter int DTR_BIT  = 10,
  parameter int RTS_BIT  = 11,
  parameter int OUT1_BIT = 12,
  parameter int OUT2_BIT = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic              lineWrEn,
  input  logic              lineBreak,
  input  logic              txWrEn,
  input  logic              extRxValid,
  output mcl_strobe_t       strobe
);
  localparam int SRC_POS [MODEM_N] = '{RTS_BIT, DTR_BIT, OUT1_BIT, OUT2_BIT};

  logic               lbeReg;
  logic               brkReg;
  logic [MODEM_N-1:0] lvlReg;
  logic [MODEM_N-1:0] wrLevels;
  logic [MODEM_N-1:0] lvlNext;
  logic               lbeNext;

  for (genvar g = 0; g < MODEM_N; g++) begin : gSrc
    assign wrLevels[g] = ctrlWrData[SRC_POS[g]];
  end

  always_comb begin
    lbeNext = ctrlWrEn ? ctrlWrData[LBE_BIT] : lbeReg;
    lvlNext = ctrlWrEn ? wrLevels : lvlReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lbeReg <= 1'b0;
      brkReg <= 1'b0;
      lvlReg <= '0;
    end else begin
      lbeReg <= lbeNext;
      lvlReg <= lvlNext;
      if (lineWrEn) brkReg <= lineBreak;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.loopNow  = lbeReg;
    strobe.loopNext = lbeNext;
    strobe.levels   = lvlNext;
    strobe.refresh  = ctrlWrEn && ctrlWrData[LBE_BIT];
    strobe.pushTx   = txWrEn && lbeReg;
    strobe.pushBrk  = lineWrEn && lineBreak && !brkReg && lbeReg;
    strobe.pushExt  = extRxValid && !lbeReg;
  end
endmodule

// File: rtl/mcl_datapath.sv
module mcl_datapath
  import mcl_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BREAK_BIT = 10,
  parameter int FLAG_W    = 9,
  parameter int CTS_POS   = 0,
  parameter int DSR_POS   = 1,
  parameter int DCD_POS   = 2,
  parameter int RI_POS    = 8,
  localparam int ENTRY_W  = BREAK_BIT + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  mcl_strobe_t        strobe,
  input  logic [DATA_W-1:0]  txData,
  input  logic [DATA_W-1:0]  extRxData,
  input  logic [MODEM_N-1:0] extModem,
  output logic [FLAG_W-1:0]  flagBits,
  output logic [MODEM_N-1:0] msIntSet,
  output logic [MODEM_N-1:0] msIntClr,
  output logic               rxPushValid,
  output logic [ENTRY_W-1:0] rxPushData
);
  localparam int FLAG_POS [MODEM_N] = '{CTS_POS, DSR_POS, DCD_POS, RI_POS};

  logic [MODEM_N-1:0] srcLevels;
  logic [FLAG_W-1:0]  flagNext;
  logic               pushNext;
  logic [ENTRY_W-1:0] entryNext;

  assign srcLevels = strobe.loopNext ? strobe.levels : extModem;

  always_comb begin
    flagNext = '0;
    for (int k = 0; k < MODEM_N; k++) flagNext[FLAG_POS[k]] = srcLevels[k];
  end

  always_comb begin
    pushNext  = 1'b1;
    entryNext = '0;
    if (strobe.pushTx)       entryNext[DATA_W-1:0] = txData;
    else if (strobe.pushBrk) entryNext[BREAK_BIT]  = 1'b1;
    else if (strobe.pushExt) entryNext[DATA_W-1:0] = extRxData;
    else                     pushNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagBits    <= '0;
      msIntSet    <= '0;
      msIntClr    <= '0;
      rxPushValid <= 1'b0;
      rxPushData  <= '0;
    end else begin
      flagBits    <= flagNext;
      msIntSet    <= strobe.refresh ? strobe.levels : '0;
      msIntClr    <= strobe.refresh ? '1 : '0;
      rxPushValid <= pushNext;
      rxPushData  <= entryNext;
    end
  end
endmodule

// File: rtl/mcl_loopback.sv
module mcl_loopback
  import mcl_pkg::*;
#(
  parameter int CTRL_W    = 16,
  parameter int DATA_W    = 8,
  parameter int BREAK_BIT = 10,
  parameter int FLAG_W    = 9,
  localparam int ENTRY_W  = BREAK_BIT + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlWrEn,
  input  logic [CTRL_W-1:0]  ctrlWrData,
  input  logic               lineWrEn,
  input  logic               lineBreak,
  input  logic               txWrEn,
  input  logic [DATA_W-1:0]  txData,
  input  logic               extRxValid,
  input  logic [DATA_W-1:0]  extRxData,
  input  logic [MODEM_N-1:0] extModem,
  output logic [FLAG_W-1:0]  flagBits,
  output logic [MODEM_N-1:0] msIntSet,
  output logic [MODEM_N-1:0] msIntClr,
  output logic               rxPushValid,
  output logic [ENTRY_W-1:0] rxPushData,
  output logic               loopbackActive
);
  mcl_strobe_t strobe;

  mcl_ctrl #(.CTRL_W(CTRL_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .lineWrEn(lineWrEn), .lineBreak(lineBreak), .txWrEn(txWrEn),
    .extRxValid(extRxValid), .strobe(strobe)
  );

  mcl_datapath #(.DATA_W(DATA_W), .BREAK_BIT(BREAK_BIT), .FLAG_W(FLAG_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txData(txData),
    .extRxData(extRxData), .extModem(extModem), .flagBits(flagBits),
    .msIntSet(msIntSet), .msIntClr(msIntClr), .rxPushValid(rxPushValid),
    .rxPushData(rxPushData)
  );

  assign loopbackActive = strobe.loopNow;
endmodule

// File: rtl/mcl_checker.sv
module mcl_checker (
  input logic        clk,
  input logic        rstN,
  input logic        ctrlWrEn,
  input logic [15:0] ctrlWrData,
  input logic        lineWrEn,
  input logic        lineBreak,
  input logic        txWrEn,
  input logic [7:0]  txData,
  input logic        extRxValid,
  input logic [3:0]  extModem,
  input logic [8:0]  flagBits,
  input logic [3:0]  msIntSet,
  input logic [3:0]  msIntClr,
  input logic        rxPushValid,
  input logic [10:0] rxPushData,
  input logic        loopbackActive
);
  logic pastOk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  AST_LOOP_MAP: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && $past(ctrlWrEn && ctrlWrData[7]) |->
      flagBits[0] == $past(ctrlWrData[11]) && flagBits[1] == $past(ctrlWrData[10]) &&
      flagBits[2] == $past(ctrlWrData[12]) && flagBits[8] == $past(ctrlWrData[13])); // R2

  AST_EXT_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && !loopbackActive |->
      {flagBits[8], flagBits[2:0]} == $past(extModem)); // R3

  AST_INT_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    msIntSet != 4'h0 |-> msIntClr == 4'hF); // R4

  AST_INT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && msIntClr != 4'h0 |-> $past(ctrlWrEn && ctrlWrData[7])); // R4

  AST_TX_LOOP: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && $past(txWrEn && loopbackActive) |->
      rxPushValid && rxPushData == {3'b000, $past(txData)}); // R5

  AST_EXT_DROP: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && $past(extRxValid && loopbackActive && !txWrEn && !lineWrEn) |->
      !rxPushValid); // R6

  AST_BREAK_SRC: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && rxPushValid && rxPushData[10] |->
      $past(lineWrEn && lineBreak && loopbackActive)); // R7

  AST_LBE_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && $past(ctrlWrEn) |-> loopbackActive == $past(ctrlWrData[7])); // R8

  AST_FLAG_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    flagBits[7:3] == 5'b0); // R9
endmodule

bind mcl_loopback mcl_checker i_mcl_checker (
  .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
  .lineWrEn(lineWrEn), .lineBreak(lineBreak), .txWrEn(txWrEn), .txData(txData),
  .extRxValid(extRxValid), .extModem(extModem), .flagBits(flagBits),
  .msIntSet(msIntSet), .msIntClr(msIntClr), .rxPushValid(rxPushValid),
  .rxPushData(rxPushData), .loopbackActive(loopbackActive)
);

// File: tb/test_mcl_loopback.sv
module test_mcl_loopback;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWrEn = 1'b0;
  logic [15:0] ctrlWrData = '0;
  logic        lineWrEn = 1'b0;
  logic        lineBreak = 1'b0;
  logic        txWrEn = 1'b0;
  logic [7:0]  txData = '0;
  logic        extRxValid = 1'b0;
  logic [7:0]  extRxData = '0;
  logic [3:0]  extModem = '0;
  logic [8:0]  flagBits;
  logic [3:0]  msIntSet;
  logic [3:0]  msIntClr;
  logic        rxPushValid;
  logic [10:0] rxPushData;
  logic        loopbackActive;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  bit checking = 0;

  always #5 clk = ~clk;

  mcl_loopback i_mcl_loopback (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .lineWrEn(lineWrEn), .lineBreak(lineBreak), .txWrEn(txWrEn), .txData(txData),
    .extRxValid(extRxValid), .extRxData(extRxData), .extModem(extModem),
    .flagBits(flagBits), .msIntSet(msIntSet), .msIntClr(msIntClr),
    .rxPushValid(rxPushValid), .rxPushData(rxPushData),
    .loopbackActive(loopbackActive)
  );

  // Behavioural reference state
  bit       mLbe, mBrk, mDtr, mRts, mOut1, mOut2;
  bit [8:0] eFlags;
  bit [3:0] eSet, eClr;
  bit       ePush;
  bit [10:0] eData;
  bit       eLbe;
  string    pushTag;

  always @(posedge clk) begin
    if (!rstN) begin
      {mLbe, mBrk, mDtr, mRts, mOut1, mOut2} = '0;
      eFlags = '0; eSet = '0; eClr = '0; ePush = 0; eData = '0; eLbe = 0;
      pushTag = "R1";
    end else begin
      bit nextLbe;
      bit [3:0] lv;
      ePush = 0; eData = '0; pushTag = "R6";
      if (txWrEn && mLbe) begin ePush = 1; eData = {3'b0, txData}; pushTag = "R5"; end
      else if (lineWrEn && lineBreak && !mBrk && mLbe) begin ePush = 1; eData = 11'h400; pushTag = "R7"; end
      else if (extRxValid && !mLbe) begin ePush = 1; eData = {3'b0, extRxData}; end
      else if (lineWrEn) pushTag = "R7";
      else if (txWrEn) pushTag = "R8";
      if (lineWrEn) mBrk = lineBreak;
      nextLbe = ctrlWrEn ? ctrlWrData[7] : mLbe;
      if (ctrlWrEn) begin
        mDtr = ctrlWrData[10]; mRts = ctrlWrData[11];
        mOut1 = ctrlWrData[12]; mOut2 = ctrlWrData[13];
      end
      lv = {mOut2, mOut1, mDtr, mRts};
      eFlags = '0;
      if (nextLbe) begin
        eFlags[0] = mRts; eFlags[1] = mDtr; eFlags[2] = mOut1; eFlags[8] = mOut2;
      end else begin
        eFlags[0] = extModem[0]; eFlags[1] = extModem[1];
        eFlags[2] = extModem[2]; eFlags[8] = extModem[3];
      end
      if (ctrlWrEn && ctrlWrData[7]) begin eSet = lv; eClr = 4'hF; end
      else begin eSet = '0; eClr = '0; end
      mLbe = nextLbe;
      eLbe = nextLbe;
    end
  end

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      check(eLbe ? "R2 flags" : "R3 flags", flagBits & 9'h107, eFlags);
      check("R9 spare flags", flagBits[7:3], 0);
      check("R4 set", msIntSet, eSet);
      check("R4 clr", msIntClr, eClr);
      check({pushTag, " push valid"}, rxPushValid, ePush);
      if (ePush) check({pushTag, " push data"}, rxPushData, eData);
      check("R8 loopback state", loopbackActive, eLbe);
    end
  end

  task automatic idle();
    ctrlWrEn = 0; lineWrEn = 0; txWrEn = 0; extRxValid = 0;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
    idle();
  endtask

  task automatic ctrlWr(bit lbe, bit dtr, bit rts, bit o1, bit o2);
    ctrlWrEn = 1; ctrlWrData = '0;
    ctrlWrData[7] = lbe; ctrlWrData[10] = dtr; ctrlWrData[11] = rts;
    ctrlWrData[12] = o1; ctrlWrData[13] = o2;
    step();
  endtask

  task automatic txWr(bit [7:0] d);
    txWrEn = 1; txData = d; step();
  endtask

  task automatic rxIn(bit [7:0] d);
    extRxValid = 1; extRxData = d; step();
  endtask

  task automatic lineWr(bit b);
    lineWrEn = 1; lineBreak = b; step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1: outputs zero under reset
    check("R1 reset flags", flagBits, 0);
    check("R1 reset push", rxPushValid, 0);
    check("R1 reset ints", {msIntSet, msIntClr}, 0);
    check("R1 reset lbe", loopbackActive, 0);
    extModem = 4'hF;
    @(negedge clk); #1;
    check("R1 reset holds flags", flagBits, 0);
    rstN = 1;
    @(negedge clk); #1;
    checking = 1;
    // R3: external pins followed
    extModem = 4'b1010; step(); step();
    extModem = 4'b0101; step(); step();
    rxIn(8'h5A); rxIn(8'hC3); step();
    // R2/R4: enable loopback with only the enable bit
    ctrlWr(1, 0, 0, 0, 0); step();
    ctrlWr(1, 1, 0, 1, 0); step();
    ctrlWr(1, 0, 1, 0, 1); ctrlWr(1, 1, 1, 1, 1); step();
    extModem = 4'b0000; step();
    // R5/R6
    txWr(8'hA5); txWr(8'h00); txWr(8'hFF); step();
    rxIn(8'h11); step();
    // R7: break edges
    lineWr(1); lineWr(1); lineWr(0); lineWr(1); lineWr(0); step();
    // R8: write disabling in same cycle as tx
    ctrlWrEn = 1; ctrlWrData = 16'h3C00; txWrEn = 1; txData = 8'h77; step();
    txWr(8'h66); rxIn(8'h22);
    // R7: break stored while off
    lineWr(1); ctrlWr(1, 0, 0, 0, 0); lineWr(1); lineWr(0); lineWr(1); step();
    // R4: write without enable, no pulse
    ctrlWr(0, 1, 1, 1, 1); step();
    // R8: enable in same cycle as external character (still accepted)
    ctrlWrEn = 1; ctrlWrData = 16'h0880; extRxValid = 1; extRxData = 8'h3E; step();
    rxIn(8'h44); step();
    // Random phase
    for (int n = 0; n < 2000; n++) begin
      int sel;
      extModem = 4'($urandom);
      ctrlWrEn = ($urandom % 5) == 0;
      ctrlWrData = 16'($urandom);
      sel = $urandom % 3;
      txWrEn = (sel == 1) && ($urandom % 2);
      lineWrEn = (sel == 2) && ($urandom % 2);
      txData = 8'($urandom);
      lineBreak = 1'($urandom);
      extRxValid = 1'($urandom);
      extRxData = 8'($urandom);
      @(negedge clk); #1;
    end
    idle(); step(); step();
    done = 1;
    checking = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule